// File: doc/BRIEF.md
# Split-Section Ripple Counter

This block is an asynchronous binary counter built from toggle stages, split into two sections that have separate clock inputs. The low section is one toggle stage that divides its clock by two. The high section is a chain of toggle stages, three by default, where each stage is clocked by the output of the stage before it. The high section therefore divides its own clock by eight. Every stage changes state on the falling edge of its clock.

The two sections can be used as two separate dividers. To build a full 4-bit counter, the low output is wired outside the block to the high clock input, and the clock is applied to the low clock input. Two clear inputs act together. When both are high, every stage is forced to zero at once, with no clock edge needed. When only one of them is high, counting goes on as usual.

Top module: `ripple_split_counter`

## Requirements
- R1: `q_lo` inverts on every falling edge of `lo_clk` while the clear is not in effect, so it divides `lo_clk` by two.
- R2: `q_hi` (bit 0 is the least significant bit) increases by one, modulo 8, on every falling edge of `hi_clk` while the clear is not in effect. After 7 it wraps to 0.
- R3: While `clr_a` and `clr_b` are both 1, `q_lo` and `q_hi` are all 0. They reach 0 without any clock edge and stay at 0 through falling edges on either clock.
- R4: When only one of `clr_a` or `clr_b` is 1, it has no effect. Both sections keep counting as in R1 and R2.
- R5: With `hi_clk` driven by `q_lo`, the value `{q_hi, q_lo}` counts up by one on each falling edge of `lo_clk`, from 0 to 15, then wraps to 0.
- R6: With the sections chained and the clear released, `q_hi[2]` has one falling edge for every 16 falling edges of `lo_clk`.
- R7: A rising edge on either clock input leaves all outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| lo_clk | input | 1 | Clock of the single low stage; the stage acts on the falling edge |
| hi_clk | input | 1 | Clock of the high chain; the chain acts on the falling edge |
| clr_a | input | 1 | First clear input; clears only together with `clr_b` |
| clr_b | input | 1 | Second clear input; clears only together with `clr_a` |
| q_lo | output | 1 | Output of the low stage (count bit 0) |
| q_hi | output | 3 | Outputs of the high chain (count bits 1 to 3, LSB at index 0) |

## Verification
The bench builds the block with the default of three high stages. This gives a high section that wraps after 8 counts and a chained counter that wraps after 16. With these sizes, every wrap point and the period of the top bit can be reached within a few dozen clock pulses. Seeded random sequences switch between separate and chained use. They mix lone clear inputs with full clears held across clock edges, and every resulting state is compared against a bench model.

// File: rtl/ripple_pkg.sv
// Shared constants for the split-section ripple counter.
// Assumes: nothing beyond a standard compile order (package first).
package ripple_pkg;
    localparam int unsigned DEF_HI_STAGES = 3;

    // Modulus of a chain of n toggle stages.
    function automatic int unsigned chain_modulus(input int unsigned n);
        return 32'd1 << n;
    endfunction
endpackage

// File: rtl/rc_clear_gate.sv
// Combines the two clear inputs: the clear is in effect only when both are high.
// Assumes: the inputs are free of glitches while both are high.
module rc_clear_gate (
    input  logic clr_a,
    input  logic clr_b,
    output logic clr
);
    // Both clear inputs must be high to clear.
    always_comb begin
        clr = clr_a & clr_b;
    end
endmodule

// File: rtl/rc_toggle_stage.sv
// One toggle flip-flop: inverts its state on the falling edge of its clock.
// Assumes: clr is an asynchronous, active-high clear to zero.
module rc_toggle_stage (
    input  logic clk_fall,
    input  logic clr,
    output logic q
);
    // Invert the state on each falling clock edge; clear forces zero.
    always_ff @(negedge clk_fall or posedge clr) begin
        if (clr) begin
            q <= 1'b0;
        end else begin
            q <= ~q;
        end
    end
endmodule

// File: rtl/rc_ripple_chain.sv
// A chain of toggle stages where each stage after the first is clocked by
// the previous stage's output, so it counts up on falling edges of clk_fall.
// Assumes: STAGES >= 1; all stages share one asynchronous clear.
module rc_ripple_chain #(
    parameter int unsigned STAGES = 3
) (
    input  logic              clk_fall,
    input  logic              clr,
    output logic [STAGES-1:0] q
);
    localparam int unsigned TAPS = STAGES + 1;

    logic [TAPS-1:0] tap;

    // Tap 0 is the external clock; tap i+1 is stage i's output.
    always_comb begin
        tap[0] = clk_fall;
    end

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        rc_toggle_stage u_stage (
            .clk_fall (tap[i]),
            .clr      (clr),
            .q        (tap[i+1])
        );
    end

    // The stage outputs form the count value.
    always_comb begin
        q = tap[TAPS-1:1];
    end
endmodule

// File: rtl/ripple_split_counter.sv
// Top of the split-section ripple counter: one divide-by-two stage on lo_clk
// and a HI_STAGES-deep ripple chain on hi_clk. Wiring q_lo to hi_clk
// externally forms a full counter of HI_STAGES+1 bits.
// Assumes: clr_a and clr_b together form an asynchronous clear.
module ripple_split_counter #(
    parameter int unsigned HI_STAGES = ripple_pkg::DEF_HI_STAGES
) (
    input  logic                 lo_clk,
    input  logic                 hi_clk,
    input  logic                 clr_a,
    input  logic                 clr_b,
    output logic                 q_lo,
    output logic [HI_STAGES-1:0] q_hi
);
    logic clr;

    rc_clear_gate u_clear (
        .clr_a (clr_a),
        .clr_b (clr_b),
        .clr   (clr)
    );

    rc_ripple_chain #(.STAGES(1)) u_lo (
        .clk_fall (lo_clk),
        .clr      (clr),
        .q        (q_lo)
    );

    rc_ripple_chain #(.STAGES(HI_STAGES)) u_hi (
        .clk_fall (hi_clk),
        .clr      (clr),
        .q        (q_hi)
    );
endmodule

// File: rtl/ripple_split_counter_chk.sv
// Assertion checker bound to ripple_split_counter.
// Assumes: a full clear is held across at least one edge of each clock, as
// the seen flags only restart after a clock edge with the clear released.
module ripple_split_counter_chk #(
    parameter int unsigned HI_STAGES = 3
) (
    input logic                 lo_clk,
    input logic                 hi_clk,
    input logic                 clr_a,
    input logic                 clr_b,
    input logic                 q_lo,
    input logic [HI_STAGES-1:0] q_hi
);
    logic clr;
    logic seen_lo;
    logic seen_hi;

    // The checker's own view of the combined clear.
    always_comb begin
        clr = clr_a & clr_b;
    end

    // Marks that a lo_clk edge has passed since the last clear.
    always_ff @(negedge lo_clk or posedge clr) begin
        if (clr) seen_lo <= 1'b0;
        else     seen_lo <= 1'b1;
    end

    // Marks that a hi_clk edge has passed since the last clear.
    always_ff @(negedge hi_clk or posedge clr) begin
        if (clr) seen_hi <= 1'b0;
        else     seen_hi <= 1'b1;
    end

    assert_lo_toggles_R1: assert property (@(negedge lo_clk) disable iff (clr)
        seen_lo |-> (q_lo != $past(q_lo)));

    assert_hi_increments_R2: assert property (@(negedge hi_clk) disable iff (clr)
        seen_hi |-> (q_hi == HI_STAGES'($past(q_hi) + 1'b1)));

    assert_clear_lo_R3: assert property (@(negedge lo_clk)
        clr |-> (q_lo == 1'b0 && q_hi == '0));

    assert_clear_hi_R3: assert property (@(negedge hi_clk)
        clr |-> (q_lo == 1'b0 && q_hi == '0));
endmodule

bind ripple_split_counter ripple_split_counter_chk #(.HI_STAGES(HI_STAGES)) u_chk (
    .lo_clk (lo_clk),
    .hi_clk (hi_clk),
    .clr_a  (clr_a),
    .clr_b  (clr_b),
    .q_lo   (q_lo),
    .q_hi   (q_hi)
);

// File: tb/ripple_split_counter_tb.sv
module ripple_split_counter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = CLK_PERIOD / 2;

    logic       lo_clk = 1'b0;
    logic       hi_drv = 1'b0;
    logic       clr_a  = 1'b0;
    logic       clr_b  = 1'b0;
    logic       chain  = 1'b0;
    logic       q_lo;
    logic [2:0] q_hi;
    logic       hi_clk;

    int checks = 0;
    int errors = 0;
    int m_lo = 0;
    int m_hi = 0;
    bit done = 0;

    assign hi_clk = chain ? q_lo : hi_drv;

    ripple_split_counter u_dut (
        .lo_clk (lo_clk),
        .hi_clk (hi_clk),
        .clr_a  (clr_a),
        .clr_b  (clr_b),
        .q_lo   (q_lo),
        .q_hi   (q_hi)
    );

    function automatic logic [3:0] model_val();
        return {3'(m_hi), 1'(m_lo)};
    endfunction

    task automatic chk(input string req, input logic [3:0] exp);
        checks++;
        if ({q_hi, q_lo} !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, {q_hi, q_lo}, exp);
        end
    endtask

    task automatic pulse_lo(input string req);
        int old;
        lo_clk = 1'b1;
        #HALF;
        chk("R7 rising lo_clk", model_val());
        lo_clk = 1'b0;
        if (!(clr_a && clr_b)) begin
            old = m_lo;
            m_lo = m_lo ^ 1;
            if (chain && old == 1) m_hi = (m_hi + 1) % 8;
        end
        #HALF;
        chk(req, model_val());
    endtask

    task automatic pulse_hi(input string req);
        hi_drv = 1'b1;
        #HALF;
        chk("R7 rising hi_clk", model_val());
        hi_drv = 1'b0;
        if (!(clr_a && clr_b)) m_hi = (m_hi + 1) % 8;
        #HALF;
        chk(req, model_val());
    endtask

    task automatic full_clear();
        clr_a = 1'b1;
        clr_b = 1'b1;
        m_lo = 0;
        m_hi = 0;
        #HALF;
        chk("R3 immediate", 4'b0000);
        pulse_lo("R3 held lo");
        if (!chain) pulse_hi("R3 held hi");
        clr_a = 1'b0;
        clr_b = 1'b0;
        #HALF;
    endtask

    task automatic set_mode(input logic c);
        full_clear();
        chain = c;
        #HALF;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int falls;
        logic prev_msb;
        void'($urandom(32'd4242));
        #1;
        full_clear();
        chk("R3 reset state", 4'b0000);

        // Separate sections: low stage divides by two.
        for (int i = 0; i < 4; i++) pulse_lo("R1 lo toggle");
        // High section alone: counts 0..7 and wraps.
        for (int i = 0; i < 10; i++) pulse_hi("R2 hi count/wrap");

        // A lone clear input has no effect.
        clr_a = 1'b1;
        #HALF;
        chk("R4 clr_a alone", model_val());
        pulse_lo("R4 clr_a alone lo");
        pulse_hi("R4 clr_a alone hi");
        clr_a = 1'b0;
        clr_b = 1'b1;
        #HALF;
        chk("R4 clr_b alone", model_val());
        pulse_lo("R4 clr_b alone lo");
        pulse_hi("R4 clr_b alone hi");
        clr_b = 1'b0;

        // Chained: full 4-bit count with wrap, and the rate of the top bit.
        set_mode(1'b1);
        falls = 0;
        prev_msb = q_hi[2];
        for (int i = 0; i < 32; i++) begin
            pulse_lo("R5 chained count");
            if (prev_msb && !q_hi[2]) falls++;
            prev_msb = q_hi[2];
        end
        checks++;
        if (falls != 2) begin
            errors++;
            $display("FAIL R6: got %0d msb falls expected 2", falls);
        end

        // Random mix of modes, lone clears and full clears.
        for (int blk = 0; blk < 8; blk++) begin
            set_mode(1'($urandom_range(0, 1)));
            for (int i = 0; i < 60; i++) begin
                int r;
                r = int'($urandom_range(0, 11));
                clr_a = 1'b0;
                clr_b = 1'b0;
                if (r == 0) full_clear();
                else begin
                    if (r == 1) clr_a = 1'b1;
                    if (r == 2) clr_b = 1'b1;
                    if (r < 7 || chain) pulse_lo(chain ? "R5 random chained" : "R1 random lo");
                    else pulse_hi("R2 random hi");
                end
            end
            clr_a = 1'b0;
            clr_b = 1'b0;
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule